// File: doc/BRIEF.md
# Single-Level Shadow Register Bank

This block holds a one-deep shadow copy of a small, fixed slice of processor state for fast context saving at handler entry. On a save command it captures four working registers and five arithmetic status flags together in a single clock. On a restore command it drives the saved copy back to the processor, marked by a one-cycle valid pulse.

The bank has exactly one level. A second save before a restore replaces the first copy without warning. That is what happens when a higher-priority handler also uses the shadow while a lower-priority handler's copy is still parked there. The only way into or out of the shadow is the two command strobes. A restore with no earlier save returns the reset contents, which are all zero. If save and restore are requested in the same cycle, the save wins and a one-cycle conflict flag is raised.

Top module: `shadow_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rst_regs` and `rst_flags` are all zero and `rst_valid` and `cmd_conflict` are low.
- R2: A save (`push`=1, `pop`=0) sampled at a clock edge captures all four registers and all five flags. Working register k sits at bits [k*REG_W +: REG_W] of `live_regs`. The flag bits are carry=0, zero=1, overflow=2, negative=3, digit carry=4. A restore issued on the very next cycle returns exactly those values in the same positions.
- R3: A restore (`pop`=1, `push`=0) sampled at edge N sets `rst_valid` high for the cycle after edge N, carrying the shadow contents. In any cycle whose preceding edge sampled no accepted restore, `rst_valid` is low.
- R4: A restore with no save since reset returns zero for every register and every flag.
- R5: A second save replaces the first completely, so a later restore returns only the second set of values.
- R6: When `push` and `pop` are both high at an edge, the live values are saved, no restore takes place (`rst_valid` stays low), and `cmd_conflict` is high for the following cycle only.
- R7: `rst_regs` and `rst_flags` change only after an accepted restore. Otherwise they hold their last value.
- R8: Changes on `live_regs` and `live_flags` without a save do not alter the shadow, and a restore does not clear it, so repeated restores return the same contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Save command strobe |
| pop | input | 1 | Restore command strobe |
| live_regs | input | NUM_REGS*REG_W | Current working registers 0..3, packed |
| live_flags | input | 5 | Current status flags (carry, zero, overflow, negative, digit carry) |
| rst_regs | output | NUM_REGS*REG_W | Restored working registers |
| rst_flags | output | 5 | Restored status flags |
| rst_valid | output | 1 | One-cycle pulse marking restored data |
| cmd_conflict | output | 1 | High for one cycle after a simultaneous save and restore |

## Verification
The assertions assume that `push` and `pop` are clean synchronous levels that are held for one whole cycle. They also assume that the live inputs are stable around each edge where a save is sampled. The bench meets both assumptions by changing every input only on the falling clock edge and by sampling outputs there too. Sweeps cover all 32 flag combinations and register patterns derived arithmetically. Within these sweeps, save/restore pairs are mixed with back-to-back saves, simultaneous commands, idle cycles and live-value churn without a save.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;
   localparam int unsigned FLAG_W = 5;
   localparam int unsigned FL_C  = 0;
   localparam int unsigned FL_Z  = 1;
   localparam int unsigned FL_OV = 2;
   localparam int unsigned FL_N  = 3;
   localparam int unsigned FL_DC = 4;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_SAVE  = 2'd1,
      CMD_LOAD  = 2'd2,
      CMD_CLASH = 2'd3
   } shadow_cmd_e;
endpackage

// File: rtl/shadow_cmd_decode.sv
`timescale 1ns/1ps
module shadow_cmd_decode
   import shadow_pkg::*;
(
   input  logic        push,
   input  logic        pop,
   output shadow_cmd_e cmd,
   output logic        save_en
);
   always_comb begin
      unique case ({push, pop})
         2'b10:   cmd = CMD_SAVE;
         2'b01:   cmd = CMD_LOAD;
         2'b11:   cmd = CMD_CLASH;
         default: cmd = CMD_NONE;
      endcase
   end

   // save has priority over restore
   assign save_en = (cmd == CMD_SAVE) || (cmd == CMD_CLASH);
endmodule

// File: rtl/shadow_slot.sv
`timescale 1ns/1ps
module shadow_slot #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("shadow_slot: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/shadow_restore.sv
`timescale 1ns/1ps
module shadow_restore
   import shadow_pkg::*;
#(
   parameter int unsigned TOT_W = 69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  shadow_cmd_e      cmd,
   input  logic [TOT_W-1:0] shadow_q,
   output logic [TOT_W-1:0] out_q,
   output logic             out_valid,
   output logic             conflict
);
   logic take;
   assign take = (cmd == CMD_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q     <= '0;
         out_valid <= 1'b0;
         conflict  <= 1'b0;
      end else begin
         out_valid <= take;
         conflict  <= (cmd == CMD_CLASH);
         if (take) out_q <= shadow_q;
      end
   end
endmodule

// File: rtl/shadow_bank.sv
`timescale 1ns/1ps
module shadow_bank
   import shadow_pkg::*;
#(
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NUM_REGS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic                      pop,
   input  logic [NUM_REGS*REG_W-1:0] live_regs,
   input  logic [FLAG_W-1:0]         live_flags,
   output logic [NUM_REGS*REG_W-1:0] rst_regs,
   output logic [FLAG_W-1:0]         rst_flags,
   output logic                      rst_valid,
   output logic                      cmd_conflict
);
   localparam int unsigned REGS_W = NUM_REGS * REG_W;
   localparam int unsigned TOT_W  = REGS_W + FLAG_W;

   generate
      if (REG_W < 1 || REG_W > 64) begin : g_bad_width
         $error("shadow_bank: REG_W out of range");
      end
      if (NUM_REGS < 1 || NUM_REGS > 16) begin : g_bad_count
         $error("shadow_bank: NUM_REGS out of range");
      end
   endgenerate

   shadow_cmd_e cmd;
   logic        save_en;
   logic [REGS_W-1:0] sh_regs;
   logic [FLAG_W-1:0] sh_flags;
   logic [TOT_W-1:0]  out_q;

   shadow_cmd_decode u_dec (
      .push    (push),
      .pop     (pop),
      .cmd     (cmd),
      .save_en (save_en)
   );

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      shadow_slot #(.W(REG_W)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (save_en),
         .d     (live_regs[k*REG_W +: REG_W]),
         .q     (sh_regs[k*REG_W +: REG_W])
      );
   end

   shadow_slot #(.W(FLAG_W)) u_flag_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (save_en),
      .d     (live_flags),
      .q     (sh_flags)
   );

   shadow_restore #(.TOT_W(TOT_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .shadow_q  ({sh_flags, sh_regs}),
      .out_q     (out_q),
      .out_valid (rst_valid),
      .conflict  (cmd_conflict)
   );

   assign rst_regs  = out_q[REGS_W-1:0];
   assign rst_flags = out_q[TOT_W-1:REGS_W];
endmodule

// File: rtl/shadow_bank_chk.sv
`timescale 1ns/1ps
module shadow_bank_chk
   import shadow_pkg::*;
#(
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NUM_REGS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      push,
   input logic                      pop,
   input logic [NUM_REGS*REG_W-1:0] live_regs,
   input logic [FLAG_W-1:0]         live_flags,
   input logic [NUM_REGS*REG_W-1:0] rst_regs,
   input logic [FLAG_W-1:0]         rst_flags,
   input logic                      rst_valid,
   input logic                      cmd_conflict
);
   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r1: assert (!rst_valid && !cmd_conflict && rst_regs == '0 && rst_flags == '0)
            else $error("R1 outputs not cleared in reset");
      end
   end

   p_save_then_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) ##1 (pop && !push) |=>
         (rst_regs == $past(live_regs, 2) && rst_flags == $past(live_flags, 2)));

   p_valid_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> rst_valid);

   p_no_stray_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && !push) |=> !rst_valid);

   p_clash_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (cmd_conflict && !rst_valid));

   p_clash_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop) |=> !cmd_conflict);

   p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_valid |-> ($stable(rst_regs) && $stable(rst_flags)));
endmodule

bind shadow_bank shadow_bank_chk #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/shadow_bank_bench.sv
`timescale 1ns/1ps
module shadow_bank_bench;
   localparam int REG_W = 16;
   localparam int NR    = 4;
   localparam int RW    = NR * REG_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push = 1'b0, pop = 1'b0;
   logic [RW-1:0] live_regs = '0;
   logic [4:0]    live_flags = '0;
   logic [RW-1:0] rst_regs;
   logic [4:0]    rst_flags;
   logic          rst_valid, cmd_conflict;

   int n_chk = 0, n_bad = 0;
   logic [RW-1:0] m_regs = '0, m_out_regs = '0;
   logic [4:0]    m_flags = '0, m_out_flags = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   shadow_bank #(.REG_W(REG_W), .NUM_REGS(NR)) u_shadow_bank (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .live_regs(live_regs), .live_flags(live_flags),
      .rst_regs(rst_regs), .rst_flags(rst_flags),
      .rst_valid(rst_valid), .cmd_conflict(cmd_conflict));

   function automatic logic [RW-1:0] pattern(int i);
      logic [RW-1:0] v;
      for (int k = 0; k < NR; k++)
         v[k*REG_W +: REG_W] = 16'((i * 16'h1357) ^ (k * 16'h0f0f) ^ (i << k));
      return v;
   endfunction

   task automatic check(string req, logic exp_v, logic exp_c);
      n_chk++;
      if (rst_valid !== exp_v || cmd_conflict !== exp_c ||
          rst_regs !== m_out_regs || rst_flags !== m_out_flags) begin
         n_bad++;
         $display("FAIL %s: got v=%b c=%b regs=%h flags=%b exp v=%b c=%b regs=%h flags=%b",
                  req, rst_valid, cmd_conflict, rst_regs, rst_flags,
                  exp_v, exp_c, m_out_regs, m_out_flags);
      end
   endtask

   // drive at falling edge, sample at next falling edge
   task automatic step(logic p, logic q, logic [RW-1:0] r, logic [4:0] f);
      push = p; pop = q; live_regs = r; live_flags = f;
      @(posedge clk);
      if (p) begin m_regs = r; m_flags = f; end
      else if (q) begin m_out_regs = m_regs; m_out_flags = m_flags; end
      @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      step(0, 0, '0, '0);
      check("R1 after release", 1'b0, 1'b0);

      // R4: restore before any save
      step(0, 1, pattern(99), 5'h1f);
      check("R4 empty restore", 1'b1, 1'b0);

      // R2/R3: sweep all flag values with save then restore
      for (int i = 0; i < 64; i++) begin
         step(1, 0, pattern(i), 5'(i));
         check("R3 no valid on save", 1'b0, 1'b0);
         step(0, 1, pattern(i + 7), 5'(~i));
         check("R2 save/restore", 1'b1, 1'b0);
      end

      // R5: nested save overwrites
      for (int i = 0; i < 8; i++) begin
         step(1, 0, pattern(200 + i), 5'(i * 3));
         step(1, 0, pattern(300 + i), 5'(i * 5 + 1));
         step(0, 1, '0, '0);
         check("R5 overwrite", 1'b1, 1'b0);
      end

      // R6: simultaneous commands
      for (int i = 0; i < 8; i++) begin
         step(1, 1, pattern(400 + i), 5'(i + 9));
         check("R6 clash", 1'b0, 1'b1);
         step(0, 0, '0, '0);
         check("R6 clash one cycle", 1'b0, 1'b0);
         step(0, 1, '0, '0);
         check("R6 clash saved", 1'b1, 1'b0);
      end

      // R7/R8: idle cycles with live churn, repeated restores
      step(1, 0, pattern(500), 5'h15);
      for (int i = 0; i < 6; i++) begin
         step(0, 0, pattern(600 + i), 5'(i));
         check("R7 hold", 1'b0, 1'b0);
      end
      for (int i = 0; i < 4; i++) begin
         step(0, 1, pattern(700 + i), 5'(i + 2));
         check("R8 repeat restore", 1'b1, 1'b0);
      end
      step(0, 0, '0, '0);
      check("R3 valid pulse ends", 1'b0, 1'b0);

      summary();
   end
endmodule